// File: doc/BRIEF.md
# Windowed Error Measurement Counter

This block measures link quality by counting error events reported by a decoder during a programmable measurement window. Each clock cycle the decoder may raise any of four event strobes: a bit error, a byte error, an uncorrectable packet, or a test-pattern (PRBS) mismatch. A separate window-unit strobe advances the measurement window. Software picks one event kind to count, picks a window length, and picks either a finite window, which ends by itself, or an infinite window, which runs until software stops it.

Software reaches the block through a plain register write port and a combinational read port. The 16-bit result is read as a low byte and a high byte. When a finite window ends, the run bit drops by itself and a sticky completion flag is raised. That flag drives the interrupt output only while its enable bit is set.

Top module: `err_window_meter`

## Requirements
- R1: After reset, all four registers read 0 and `irq_o` is 0. The registers are: control at address 0, status at address 1, count low byte at address 2, count high byte at address 3.
- R2: Control bits [5:4] select the counted kind: 00 bit error (`evt_i[0]`), 01 byte error (`evt_i[1]`), 10 uncorrectable packet (`evt_i[2]`), 11 PRBS error (`evt_i[3]`). While control bit 0 (run) is 1, the count rises by exactly one on each clock edge where the selected strobe is high, and other strobes have no effect.
- R3: A control write with bit 0 = 1 clears the count and the window position on that edge, and the strobe on that edge is not counted. This also applies while a run is active, which restarts it.
- R4: When control bit 1 is 0 (finite), the window lasts 1024·4^s window-unit strobes, where s is control bits [3:2] (00→1024, 01→4096, 10→16384, 11→65536). The run bit clears itself on the edge that takes the last strobe. Cycles without `win_tick_i` do not advance the window.
- R5: When control bit 1 is 1 (infinite), the run bit stays 1 and counting continues past every window length. No completion is raised.
- R6: The count saturates at 0xFFFF and never wraps.
- R7: Address 2 returns count bits [7:0] and address 3 returns count bits [15:8].
- R8: Status bit 0 is a sticky completion flag. It is set when a finite window ends and cleared only by writing 1 to status bit 0. Writing 0 there has no effect.
- R9: If a finite window ends on the same edge as a write of 1 to status bit 0, the flag stays set.
- R10: `irq_o` equals the completion flag ANDed with control bit 6 (interrupt enable).
- R11: While run is 1, a control write leaves the kind field [5:4] and the window field [3:2] unchanged. These fields take new values only when written while run is 0.
- R12: A control write with bit 0 = 0 stops a run. The count then holds, and the completion flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 4 | Per-cycle error strobes: [0] bit, [1] byte, [2] packet, [3] PRBS |
| win_tick_i | input | 1 | Window-unit strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Measurement-complete interrupt |

## Verification
Two pairs of events can fall on the same edge. The first pair is a finite window ending and a software write that clears the completion flag. The bench provokes this by issuing the clear write exactly on the 1024th window strobe of a run, then expects the flag to remain set and the run bit to be low. The second pair is a restart write and an active error strobe. The bench holds every strobe high during a restart write issued mid-run and expects a count of zero afterwards, with the locked kind and window fields read back unchanged.

// File: rtl/errmeter_pkg.sv
package errmeter_pkg;

   // Register addresses; count bytes follow the status register.
   localparam int unsigned ADDR_CTRL  = 0;
   localparam int unsigned ADDR_STAT  = 1;
   localparam int unsigned ADDR_CNT0  = 2;

   // Fixed control bit positions.
   localparam int unsigned POS_GO     = 0;
   localparam int unsigned POS_INF    = 1;
   localparam int unsigned POS_SPAN   = 2;

   // Status bit position.
   localparam int unsigned POS_FLAG   = 0;

   typedef enum logic [1:0] {
      KIND_BIT  = 2'b00,
      KIND_BYTE = 2'b01,
      KIND_PKT  = 2'b10,
      KIND_PRBS = 2'b11
   } err_kind_e;

endpackage

// File: rtl/errmeter_ctrl.sv
module errmeter_ctrl
   import errmeter_pkg::*;
#(
   parameter int unsigned SPAN_W = 2,
   parameter int unsigned KIND_W = 2,
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              done_i,
   output logic              go_o,
   output logic              inf_o,
   output logic [SPAN_W-1:0] span_o,
   output logic [KIND_W-1:0] kind_o,
   output logic              ien_o,
   output logic              flag_o,
   output logic              restart_o
);

   localparam int unsigned POS_KIND = POS_SPAN + SPAN_W;
   localparam int unsigned POS_IEN  = POS_KIND + KIND_W;

   if (POS_IEN >= DATA_W) begin : g_bad_fields
      $error("control fields do not fit the data width");
   end

   logic              go_q, inf_q, ien_q, flag_q;
   logic [SPAN_W-1:0] span_q;
   logic [KIND_W-1:0] kind_q;
   logic              ctrl_wr, stat_clr;

   assign ctrl_wr   = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL));
   assign stat_clr  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_STAT)) && wr_data_i[POS_FLAG];
   assign restart_o = ctrl_wr && wr_data_i[POS_GO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go_q   <= 1'b0;
         inf_q  <= 1'b0;
         ien_q  <= 1'b0;
         span_q <= '0;
         kind_q <= '0;
      end else if (ctrl_wr) begin
         go_q  <= wr_data_i[POS_GO];
         inf_q <= wr_data_i[POS_INF];
         ien_q <= wr_data_i[POS_IEN];
         if (!go_q) begin
            span_q <= wr_data_i[POS_SPAN +: SPAN_W];
            kind_q <= wr_data_i[POS_KIND +: KIND_W];
         end
      end else if (done_i) begin
         go_q <= 1'b0;
      end
   end

   // Completion sets the flag; a set on the same edge beats a clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (done_i)   flag_q <= 1'b1;
      else if (stat_clr) flag_q <= 1'b0;
   end

   assign go_o   = go_q;
   assign inf_o  = inf_q;
   assign span_o = span_q;
   assign kind_o = kind_q;
   assign ien_o  = ien_q;
   assign flag_o = flag_q;

   a_r11_lock_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (go_q && ctrl_wr) |=> ($stable(kind_q) && $stable(span_q)));

   a_r4_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !ctrl_wr) |=> !go_q);

   a_r5_inf_persists: assert property (@(posedge clk) disable iff (!rst_n)
      (go_q && inf_q && !ctrl_wr) |=> go_q);

   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> flag_q);

   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_i && !stat_clr) |=> $stable(flag_q));

endmodule

// File: rtl/errmeter_window.sv
module errmeter_window #(
   parameter int unsigned SPAN_W    = 2,
   parameter int unsigned BASE_LOG2 = 10,
   parameter int unsigned STEP_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic              inf_i,
   input  logic [SPAN_W-1:0] span_i,
   input  logic              tick_i,
   input  logic              restart_i,
   output logic              done_o
);

   localparam int unsigned NUM_SPANS = 1 << SPAN_W;
   localparam int unsigned WIN_W     = BASE_LOG2 + STEP_LOG2 * (NUM_SPANS - 1);

   if (BASE_LOG2 < 1) begin : g_bad_base
      $error("window base must be at least two units");
   end

   logic [WIN_W-1:0] lim_tab [NUM_SPANS];
   logic [WIN_W-1:0] pos_q;
   logic             last;

   // Last position of each window length, one entry per span code.
   for (genvar g = 0; g < NUM_SPANS; g++) begin : g_lim
      localparam int unsigned SH = BASE_LOG2 + STEP_LOG2 * g;
      assign lim_tab[g] = {WIN_W{1'b1}} >> (WIN_W - SH);
   end

   assign last   = (pos_q == lim_tab[span_i]);
   assign done_o = go_i && !inf_i && tick_i && last && !restart_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pos_q <= '0;
      else if (restart_i)        pos_q <= '0;
      else if (go_i && tick_i)   pos_q <= last ? '0 : pos_q + 1'b1;
   end

   a_r3_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (pos_q == '0));

   a_r4_tick_gates: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !restart_i) |=> $stable(pos_q));

endmodule

// File: rtl/errmeter_accum.sv
module errmeter_accum #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned KIND_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [(1<<KIND_W)-1:0] evt_i,
   input  logic [KIND_W-1:0]     kind_i,
   input  logic                  go_i,
   input  logic                  restart_i,
   output logic [CNT_W-1:0]      cnt_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             hit, at_top;

   assign hit    = evt_i[kind_i];
   assign at_top = &cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (restart_i)                  cnt_q <= '0;
      else if (go_i && hit && !at_top)     cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   a_r3_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (cnt_q == '0));

   a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart_i && (&cnt_q)) |=> (&cnt_q));

   a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      !restart_i |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));

   a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!go_i && !restart_i) |=> $stable(cnt_q));

endmodule

// File: rtl/err_window_meter.sv
module err_window_meter
   import errmeter_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned KIND_W    = 2,
   parameter int unsigned SPAN_W    = 2,
   parameter int unsigned BASE_LOG2 = 10,
   parameter int unsigned STEP_LOG2 = 2,
   parameter int unsigned DATA_W    = 8,
   localparam int unsigned NBYTES   = CNT_W / DATA_W,
   localparam int unsigned NKINDS   = 1 << KIND_W,
   localparam int unsigned ADDR_W   = $clog2(ADDR_CNT0 + NBYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NKINDS-1:0] evt_i,
   input  logic              win_tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_o
);

   if (CNT_W % DATA_W != 0 || CNT_W < DATA_W) begin : g_bad_cnt
      $error("count width must be a whole number of data bytes");
   end

   localparam int unsigned POS_KIND = POS_SPAN + SPAN_W;
   localparam int unsigned POS_IEN  = POS_KIND + KIND_W;

   logic              go, inf, ien, flag, restart, done;
   logic [SPAN_W-1:0] span;
   logic [KIND_W-1:0] kind;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] cnt_byte [NBYTES];
   logic [DATA_W-1:0] ctrl_view;

   errmeter_ctrl #(
      .SPAN_W (SPAN_W),
      .KIND_W (KIND_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .done_i    (done),
      .go_o      (go),
      .inf_o     (inf),
      .span_o    (span),
      .kind_o    (kind),
      .ien_o     (ien),
      .flag_o    (flag),
      .restart_o (restart)
   );

   errmeter_window #(
      .SPAN_W    (SPAN_W),
      .BASE_LOG2 (BASE_LOG2),
      .STEP_LOG2 (STEP_LOG2)
   ) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_i      (go),
      .inf_i     (inf),
      .span_i    (span),
      .tick_i    (win_tick_i),
      .restart_i (restart),
      .done_o    (done)
   );

   errmeter_accum #(
      .CNT_W  (CNT_W),
      .KIND_W (KIND_W)
   ) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_i),
      .kind_i    (kind),
      .go_i      (go),
      .restart_i (restart),
      .cnt_o     (cnt)
   );

   for (genvar b = 0; b < NBYTES; b++) begin : g_bytes
      assign cnt_byte[b] = cnt[b*DATA_W +: DATA_W];
   end

   always_comb begin
      ctrl_view = '0;
      ctrl_view[POS_GO]              = go;
      ctrl_view[POS_INF]             = inf;
      ctrl_view[POS_SPAN +: SPAN_W]  = span;
      ctrl_view[POS_KIND +: KIND_W]  = kind;
      ctrl_view[POS_IEN]             = ien;
   end

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == ADDR_W'(ADDR_CTRL)) rd_data_o = ctrl_view;
      if (rd_addr_i == ADDR_W'(ADDR_STAT)) rd_data_o[POS_FLAG] = flag;
      for (int b = 0; b < NBYTES; b++) begin
         if (rd_addr_i == ADDR_W'(ADDR_CNT0 + b)) rd_data_o = cnt_byte[b];
      end
   end

   assign irq_o = flag && ien;

   a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (flag && ien));

endmodule

// File: tb/err_window_meter_bench.sv
module err_window_meter_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] evt = 4'h0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       irq;

   int errs = 0;
   int checks = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk = ~clk;

   err_window_meter u_err_window_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt),
      .win_tick_i (tick),
      .wr_en_i    (wr_en),
      .wr_addr_i  (wr_addr),
      .wr_data_i  (wr_data),
      .rd_addr_i  (rd_addr),
      .rd_data_o  (rd_data),
      .irq_o      (irq)
   );

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Called at a falling edge; the write lands on the next rising edge.
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int d);
      rd_addr = a;
      #1;
      d = int'(rd_data);
   endtask

   task automatic rd_count(output int c);
      int lo, hi;
      rd(2, lo);
      rd(3, hi);
      c = hi * 256 + lo;
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   function automatic logic [7:0] ctrl(input int go, input int inf, input int span,
                                       input int kind, input int ien);
      return 8'(go | (inf << 1) | (span << 2) | (kind << 4) | (ien << 6));
   endfunction

   // Start a finite window and drive strobes until run drops.
   task automatic finite_run(input int kind, input int span, input bit half_tick,
                             input bit all_ones, input int ien,
                             output int cycles, output int ticks, output int expv);
      int d;
      evt = 4'h0; tick = 1'b0;
      wr(0, ctrl(1, 0, span, kind, ien));
      cycles = 0; ticks = 0; expv = 0;
      for (int i = 0; i < 150000; i++) begin
         step_lfsr();
         evt  = all_ones ? 4'hF : lfsr[3:0];
         tick = half_tick ? (i % 2 == 1) : 1'b1;
         if (evt[kind]) expv++;
         if (tick) ticks++;
         cycles++;
         @(negedge clk);
         rd(0, d);
         if ((d & 1) == 0) break;
      end
      evt = 4'h0; tick = 1'b0;
      if (expv > 65535) expv = 65535;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      summary();
      $finish;
   end

   initial begin
      int d, c, cyc, tk, ex;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         chk("R1 register after reset", d, 0);
      end
      chk("R1 irq after reset", int'(irq), 0);

      // R2 / R4 / R7 / R8 / R10: one finite run per kind and window length
      for (int s = 0; s < 3; s++) begin
         finite_run(s, s, 1'b0, 1'b0, 1, cyc, tk, ex);
         chk("R4 window length in cycles", cyc, 1024 << (2 * s));
         rd_count(c);
         chk("R2 R7 count of selected kind", c, ex);
         rd(1, d);
         chk("R8 flag set at completion", d & 1, 1);
         chk("R10 irq with enable", int'(irq), 1);
         wr(1, 8'h00);
         rd(1, d);
         chk("R8 writing 0 keeps flag", d & 1, 1);
         wr(1, 8'h01);
         rd(1, d);
         chk("R8 write 1 clears flag", d & 1, 0);
         chk("R10 irq after clear", int'(irq), 0);
      end

      // R4 sparse window strobes
      finite_run(2, 0, 1'b1, 1'b0, 1, cyc, tk, ex);
      chk("R4 strobes consumed", tk, 1024);
      chk("R4 cycles with half-rate strobe", cyc, 2048);
      rd_count(c);
      chk("R2 packet count", c, ex);

      // R6 / R7 saturation over the longest window
      finite_run(3, 3, 1'b0, 1'b1, 1, cyc, tk, ex);
      chk("R4 longest window", cyc, 65536);
      rd(2, d);
      chk("R7 R6 low byte saturated", d, 255);
      rd(3, d);
      chk("R7 R6 high byte saturated", d, 255);

      // R9 completion coincides with a clear (flag already set)
      wr(0, ctrl(1, 0, 0, 0, 1));
      tick = 1'b1;
      repeat (1023) @(negedge clk);
      wr(1, 8'h01);
      tick = 1'b0;
      rd(1, d);
      chk("R9 set beats clear", d & 1, 1);
      rd(0, d);
      chk("R4 run dropped at window end", d & 1, 0);
      wr(1, 8'h01);
      rd(1, d);
      chk("R8 later clear", d & 1, 0);

      // R10 enable gating
      finite_run(0, 0, 1'b0, 1'b0, 0, cyc, tk, ex);
      rd(1, d);
      chk("R10 flag set with enable off", d & 1, 1);
      chk("R10 irq masked", int'(irq), 0);
      wr(0, ctrl(0, 0, 0, 0, 1));
      chk("R10 irq when enabled", int'(irq), 1);
      wr(1, 8'h01);

      // R3 restart mid-window restarts the window
      wr(0, ctrl(1, 0, 0, 0, 1));
      tick = 1'b1;
      repeat (500) @(negedge clk);
      finite_run(0, 0, 1'b0, 1'b0, 1, cyc, tk, ex);
      chk("R3 restart gives full window", cyc, 1024);
      wr(1, 8'h01);

      // R11 / R3 / R5 / R12 infinite mode with locked fields
      wr(0, ctrl(1, 1, 0, 1, 0));
      tick = 1'b1;
      for (int i = 0; i < 10; i++) begin
         step_lfsr(); evt = lfsr[3:0];
         @(negedge clk);
      end
      evt = 4'hF;
      wr(0, ctrl(1, 1, 3, 3, 0));
      evt = 4'h0;
      rd(0, d);
      chk("R11 kind locked", (d >> 4) & 3, 1);
      chk("R11 span locked", (d >> 2) & 3, 0);
      rd_count(c);
      chk("R3 restart clears count", c, 0);
      ex = 0;
      for (int i = 0; i < 3000; i++) begin
         step_lfsr(); evt = lfsr[3:0];
         if (evt[1]) ex++;
         @(negedge clk);
      end
      evt = 4'h0;
      rd(0, d);
      chk("R5 run stays on", d & 1, 1);
      rd(1, d);
      chk("R5 no completion", d & 1, 0);
      rd_count(c);
      chk("R5 R2 byte count", c, ex);
      wr(0, ctrl(0, 1, 0, 1, 0));
      evt = 4'hF;
      repeat (20) @(negedge clk);
      evt = 4'h0; tick = 1'b0;
      rd(0, d);
      chk("R12 stopped", d & 1, 0);
      rd_count(c);
      chk("R12 count holds", c, ex);
      rd(1, d);
      chk("R12 no flag on stop", d & 1, 0);
      wr(0, ctrl(0, 0, 3, 3, 0));
      rd(0, d);
      chk("R11 kind writable when idle", (d >> 4) & 3, 3);
      chk("R11 span writable when idle", (d >> 2) & 3, 3);

      summary();
      $finish;
   end

endmodule